// File: doc/BRIEF.md
# Multichannel ADC Engine Control and Channel Scanner

This block is the digital control core of a multichannel analog-to-digital converter. A single 32-bit engine control word carries the engine enable, a 3-bit operating mode, the reference-range select, two compensation bits, the battery-sensing controls and a 16-bit mask of channel enables. Once the engine is enabled in normal mode, a start-up phase counts a set number of converter sample strobes and then raises a read-only ready flag. Only after that does the block start converting.

While ready, the block walks the enabled channels in ascending order, one channel per sample strobe, and wraps around after the highest one. The converter is modelled as a strobe plus a 10-bit code. On each strobe the block captures the code for the channel it is presenting on `smp_chan`, and the result can then be read as a 16-bit halfword. When channel 7 is selected in battery mode, a side output tells the analog front end to route the battery divider to the converter.

Software reaches the block through a simple word-aligned register port. This port rejects misaligned addresses and addresses past the top of the window. It also holds a 4-bit trim value that never reads as zero.

Top module: `adc_ctrl_core`

## Requirements
- R1: After reset the control word reads 0, the trim register (offset 0xC4) reads 8, every data halfword reads 0, and `smp_active` and `bat_sel` are low.
- R2: A write to offset 0x00 stores bit 0 (enable), bits 3:1 (mode), bits 4 and 5 (compensation), bits 7:6 (reference), bit 12 (channel 7 battery mode), bit 13 (battery sensing enable) and bits 31:16 (channel enables). Bits 11:8 and 15:14 are not writable and read 0, except bit 8, which shows the ready flag.
- R3: With enable = 1 and mode = 7 (normal), the ready flag (bit 8) rises on the INIT_STROBES-th sample strobe and no sooner. No conversion is issued while it is low.
- R4: The cycle after the mode leaves 7 or the enable bit is cleared, the ready flag reads 0. Returning to normal mode repeats the full start-up count and restarts the scan at channel 0.
- R5: While ready, each strobe converts the lowest enabled channel at or above the scan position. The position then moves one past that channel and wraps from the top channel back to 0. Disabled channels are never presented.
- R6: The code captured on a strobe is stored for the presented channel. Channel n reads as a zero-extended 16-bit value at byte offset 0x10 + 2·n, so the word at 0x10 + 4·k holds channel 2k in bits 15:0 and channel 2k+1 in bits 31:16.
- R7: In standby, power-down, with the engine disabled, before ready, or with no channel enabled, `smp_active` stays low, strobes store nothing, and all data halfwords keep their values.
- R8: `bat_sel` is high exactly when channel 7 is being presented for conversion while control bits 12 and 13 are both set.
- R9: An access with address bits 1:0 not zero, or with an address above 0xD0, raises `bus_err`, reads 0, and leaves all registers unchanged on write.
- R10: Offset 0xC4 holds a 4-bit trim taken from wdata bits 3:0; a written value of 0 is stored as 8.
- R11: Aligned offsets 0x04–0x0C, 0xC8, 0xCC and 0xD0 read 0 without error, and writes to them change nothing. Data halfwords are not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access rejected (misaligned or out of window) |
| smp_strobe | input | 1 | Converter sample strobe, one cycle per sample |
| smp_code | input | CODE_W | Converter result for the presented channel |
| smp_chan | output | CH_W | Channel presented to the converter |
| smp_active | output | 1 | A conversion is issued on the next strobe |
| bat_sel | output | 1 | Route battery divider to channel 7 input |

## Verification
The bench keeps the full 16 channels and 10-bit codes, but sets INIT_STROBES to 3. This brings the ready-flag edge and its restart after a mode change within a few strobes. With the full channel count, the bench can reach a scan that wraps from channel 15 back to channel 1, and it can read the top data word, where channel 15 sits in the upper halfword. Channel 7 exists at this size, so the battery-select variant is built and exercised with and without its two control bits.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef struct packed {
        logic [15:0] chan_en;
        logic [1:0]  rsv_hi;
        logic        bat_en;
        logic        ch7_bat;
        logic [2:0]  rsv_mid;
        logic        init_rdy;
        logic [1:0]  vref_sel;
        logic        auto_comp;
        logic        comp_en;
        logic [2:0]  mode;
        logic        eng_en;
    } ctrl_word_t;

    localparam logic [2:0]  MODE_OFF     = 3'd0;
    localparam logic [2:0]  MODE_STBY    = 3'd1;
    localparam logic [2:0]  MODE_RUN     = 3'd7;

    localparam logic [7:0]  OFS_CTRL     = 8'h00;
    localparam logic [7:0]  OFS_DATA     = 8'h10;
    localparam logic [7:0]  OFS_TRIM     = 8'hC4;
    localparam logic [7:0]  OFS_LIMIT    = 8'hD0;

    localparam logic [31:0] CTRL_WR_MASK = 32'hFFFF_30FF;
    localparam logic [3:0]  TRIM_DEFAULT = 4'h8;
    localparam int          BAT_CH       = 7;

endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int CODE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_err,
    input  logic                  init_rdy,
    input  logic [NCH*CODE_W-1:0] data_flat,
    output ctrl_word_t            ctrl_o
);
    localparam logic [7:0] DATA_END = 8'(int'(OFS_DATA) + 2 * NCH);

    typedef struct packed {
        ctrl_word_t ctrl;
        logic [3:0] trim;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       acc_ok;

    always_comb begin
        int         lo_ch;
        int         hi_ch;
        ctrl_word_t rd_ctrl;
        st_d      = st_q;
        bus_rdata = '0;
        bus_err   = 1'b0;
        acc_ok    = (bus_addr[1:0] == 2'b00) && (bus_addr <= OFS_LIMIT);
        lo_ch     = 0;
        hi_ch     = 0;
        rd_ctrl   = st_q.ctrl;
        rd_ctrl.init_rdy = init_rdy;
        if (bus_valid) begin
            if (!acc_ok) begin
                bus_err = 1'b1;
            end else if (bus_addr == OFS_CTRL) begin
                bus_rdata = rd_ctrl;
                if (bus_write) st_d.ctrl = ctrl_word_t'(bus_wdata & CTRL_WR_MASK);
            end else if (bus_addr == OFS_TRIM) begin
                bus_rdata = {28'd0, st_q.trim};
                if (bus_write)
                    st_d.trim = (bus_wdata[3:0] == 4'd0) ? TRIM_DEFAULT : bus_wdata[3:0];
            end else if (bus_addr >= OFS_DATA && bus_addr < DATA_END) begin
                lo_ch = int'(bus_addr - OFS_DATA) >> 1;
                hi_ch = (lo_ch + 1 < NCH) ? lo_ch + 1 : lo_ch;
                bus_rdata[CODE_W-1:0] = data_flat[lo_ch*CODE_W +: CODE_W];
                if (lo_ch + 1 < NCH)
                    bus_rdata[16 +: CODE_W] = data_flat[hi_ch*CODE_W +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.trim <= TRIM_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

    p_trim_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trim != 4'd0);
    p_misalign_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[1:0] != 2'b00) |-> (bus_err && bus_rdata == '0));
    p_bad_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_err) |=> $stable(st_q));

endmodule

// File: rtl/adc_ctrl_scan.sv
module adc_ctrl_scan
    import adc_ctrl_pkg::*;
#(
    parameter int NCH          = 16,
    parameter int INIT_STROBES = 8,
    localparam int CH_W        = $clog2(NCH),
    localparam int CNT_W       = $clog2(INIT_STROBES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_en,
    input  logic [2:0]      mode,
    input  logic [NCH-1:0]  chan_en,
    input  logic            strobe,
    output logic            ready,
    output logic            active,
    output logic [CH_W-1:0] sel_chan,
    output logic            wr_en
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
        logic [CH_W-1:0]  ptr;
    } scan_state_t;

    scan_state_t st_d, st_q;
    logic        run_mode;
    logic        found;

    assign run_mode = eng_en && (mode == MODE_RUN);

    always_comb begin
        found    = 1'b0;
        sel_chan = st_q.ptr;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (int'(st_q.ptr) + i) % NCH;
            if (!found && chan_en[idx]) begin
                found    = 1'b1;
                sel_chan = CH_W'(idx);
            end
        end
    end

    assign active = st_q.ready && run_mode && found;
    assign wr_en  = active && strobe;
    assign ready  = st_q.ready;

    always_comb begin
        st_d = st_q;
        if (!run_mode) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
            st_d.ptr   = '0;
        end else if (!st_q.ready) begin
            if (strobe) begin
                if (int'(st_q.cnt) == INIT_STROBES - 1) begin
                    st_d.cnt   = '0;
                    st_d.ready = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else if (wr_en) begin
            st_d.ptr = CH_W'((int'(sel_chan) + 1) % NCH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && !run_mode) |=> !st_q.ready);
    p_ready_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> $past(strobe));

endmodule

// File: rtl/adc_ctrl_store.sv
module adc_ctrl_store #(
    parameter int NCH    = 16,
    parameter int CODE_W = 10,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic [CODE_W-1:0]     wr_code,
    output logic [NCH*CODE_W-1:0] data_flat
);
    logic [CODE_W-1:0] data_d [NCH];
    logic [CODE_W-1:0] data_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_comb begin
            data_d[g] = data_q[g];
            if (wr_en && wr_chan == CH_W'(g)) data_d[g] = wr_code;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) data_q[g] <= '0;
            else        data_q[g] <= data_d[g];
        end
        assign data_flat[g*CODE_W +: CODE_W] = data_q[g];
    end

endmodule

// File: rtl/adc_ctrl_core.sv
module adc_ctrl_core
    import adc_ctrl_pkg::*;
#(
    parameter int NCH          = 16,
    parameter int CODE_W       = 10,
    parameter int INIT_STROBES = 8,
    localparam int CH_W        = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              smp_strobe,
    input  logic [CODE_W-1:0] smp_code,
    output logic [CH_W-1:0]   smp_chan,
    output logic              smp_active,
    output logic              bat_sel
);
    ctrl_word_t            ctrl;
    logic                  init_rdy;
    logic                  wr_en;
    logic [NCH*CODE_W-1:0] data_flat;

    adc_ctrl_regs #(.NCH(NCH), .CODE_W(CODE_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .init_rdy  (init_rdy),
        .data_flat (data_flat),
        .ctrl_o    (ctrl)
    );

    adc_ctrl_scan #(.NCH(NCH), .INIT_STROBES(INIT_STROBES)) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_en   (ctrl.eng_en),
        .mode     (ctrl.mode),
        .chan_en  (ctrl.chan_en[NCH-1:0]),
        .strobe   (smp_strobe),
        .ready    (init_rdy),
        .active   (smp_active),
        .sel_chan (smp_chan),
        .wr_en    (wr_en)
    );

    adc_ctrl_store #(.NCH(NCH), .CODE_W(CODE_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_chan   (smp_chan),
        .wr_code   (smp_code),
        .data_flat (data_flat)
    );

    if (NCH > BAT_CH) begin : g_bat
        assign bat_sel = smp_active && (int'(smp_chan) == BAT_CH)
                         && ctrl.ch7_bat && ctrl.bat_en;
    end else begin : g_no_bat
        assign bat_sel = 1'b0;
    end

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_active && smp_strobe) |=> $stable(data_flat));
    p_chan_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_active |-> ctrl.chan_en[smp_chan]);
    p_bat_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> (smp_active && int'(smp_chan) == BAT_CH));
    p_active_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_active |-> init_rdy);

endmodule

// File: tb/test_adc_ctrl_core.sv
module test_adc_ctrl_core;
    localparam int NCH = 16;
    localparam int CODE_W = 10;
    localparam int INIT = 3;
    localparam int CH_W = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err;
    logic smp_strobe = 1'b0;
    logic [CODE_W-1:0] smp_code = '0;
    logic [CH_W-1:0] smp_chan;
    logic smp_active, bat_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_ctrl_core #(.NCH(NCH), .CODE_W(CODE_W), .INIT_STROBES(INIT)) i_adc_ctrl_core (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .smp_strobe(smp_strobe), .smp_code(smp_code),
        .smp_chan(smp_chan), .smp_active(smp_active), .bat_sel(bat_sel));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; e = bus_err;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic strobe(input logic [CODE_W-1:0] c, output int ch, output logic act, output logic bs);
        @(negedge clk);
        smp_strobe = 1'b1; smp_code = c;
        #1;
        ch = int'(smp_chan); act = smp_active; bs = bat_sel;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        rd(8'h00, d, e); chk("R1 ctrl", d, 32'h0); chk("R1 err", {31'd0, e}, 32'd0);
        rd(8'hC4, d, e); chk("R1 trim", d, 32'h8);
        rd(8'h10, d, e); chk("R1 data", d, 32'h0);
        chk("R1 active", {30'd0, smp_active, bat_sel}, 32'd0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] d; logic e;
        wr(8'h00, 32'hFFFF_FFF0);
        rd(8'h00, d, e); chk("R2 writable mask", d, 32'hFFFF_30F0);
        wr(8'h00, 32'h0);
        rd(8'h00, d, e); chk("R2 cleared", d, 32'h0);
    endtask

    task automatic t_trim();
        logic [31:0] d; logic e;
        wr(8'hC4, 32'h5); rd(8'hC4, d, e); chk("R10 trim 5", d, 32'h5);
        wr(8'hC4, 32'h0); rd(8'hC4, d, e); chk("R10 trim zero->8", d, 32'h8);
        wr(8'hC4, 32'h1F3); rd(8'hC4, d, e); chk("R10 trim 4 bits", d, 32'h3);
    endtask

    task automatic t_errors();
        logic [31:0] d; logic e;
        wr(8'h00, 32'h0000_0010);
        rd(8'h02, d, e); chk("R9 misaligned err", {31'd0, e}, 32'd1); chk("R9 misaligned rdata", d, 32'h0);
        rd(8'hD4, d, e); chk("R9 high err", {31'd0, e}, 32'd1);
        wr(8'h01, 32'hFFFF_FFFF); rd(8'h00, d, e); chk("R9 write ignored", d, 32'h0000_0010);
        rd(8'hD0, d, e); chk("R11 D0 no err", {31'd0, e}, 32'd0); chk("R11 D0 zero", d, 32'h0);
        wr(8'hC8, 32'hFFFF_FFFF); rd(8'hC8, d, e); chk("R11 C8 zero", d, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d, e); chk("R11 08 zero", d, 32'h0);
        rd(8'h00, d, e); chk("R11 ctrl untouched", d, 32'h0000_0010);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_init_and_scan();
        logic [31:0] d; logic e; int ch; logic act, bs;
        wr(8'h00, 32'h0005_000F);
        for (int i = 0; i < INIT - 1; i++) begin
            strobe(10'h111, ch, act, bs); chk("R3 no conversion in init", {31'd0, act}, 32'd0);
        end
        rd(8'h00, d, e); chk("R3 not ready early", {31'd0, d[8]}, 32'd0);
        strobe(10'h111, ch, act, bs);
        rd(8'h00, d, e); chk("R3 ready after count", {31'd0, d[8]}, 32'd1);
        rd(8'h10, d, e); chk("R7 init stores nothing", d, 32'h0);
        strobe(10'h3FF, ch, act, bs); chk("R5 first ch0", ch, 0); chk("R5 active", {31'd0, act}, 32'd1);
        strobe(10'h155, ch, act, bs); chk("R5 then ch2", ch, 2);
        strobe(10'h2AA, ch, act, bs); chk("R5 wrap ch0", ch, 0);
        strobe(10'h001, ch, act, bs); chk("R5 ch2 again", ch, 2);
        rd(8'h10, d, e); chk("R6 word 0x10", d, 32'h0000_02AA);
        rd(8'h14, d, e); chk("R6 word 0x14", d, 32'h0000_0001);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d, e); chk("R11 data read-only", d, 32'h0000_02AA);
        wr(8'h00, 32'h800A_000F);
        strobe(10'h033, ch, act, bs); chk("R5 next ch3", ch, 3);
        strobe(10'h244, ch, act, bs); chk("R5 next ch15", ch, 15);
        strobe(10'h0CC, ch, act, bs); chk("R5 wrap ch1", ch, 1);
        rd(8'h2C, d, e); chk("R6 top word ch15 high", d, 32'h0244_0000);
        rd(8'h10, d, e); chk("R6 ch1 high half", d, 32'h00CC_02AA);
    endtask

    task automatic t_battery();
        logic [31:0] d; logic e; int ch; logic act, bs;
        wr(8'h00, 32'h0080_300F);
        strobe(10'h1AB, ch, act, bs); chk("R8 ch7 presented", ch, 7); chk("R8 bat_sel on", {31'd0, bs}, 32'd1);
        wr(8'h00, 32'h0080_200F);
        strobe(10'h1AC, ch, act, bs); chk("R8 bat_sel needs bit12", {31'd0, bs}, 32'd0);
        rd(8'h1C, d, e); chk("R6 ch7 stored", d, 32'h01AC_0000);
    endtask

    task automatic t_idle();
        logic [31:0] d; logic e; int ch; logic act, bs;
        wr(8'h00, 32'h0080_3003);
        rd(8'h00, d, e); chk("R4 ready cleared in standby", {31'd0, d[8]}, 32'd0);
        strobe(10'h3C3, ch, act, bs); chk("R7 standby inactive", {30'd0, act, bs}, 32'd0);
        rd(8'h1C, d, e); chk("R7 standby holds data", d, 32'h01AC_0000);
        wr(8'h00, 32'h0000_000F);
        for (int i = 0; i < INIT; i++) strobe(10'h000, ch, act, bs);
        rd(8'h00, d, e); chk("R4 ready again after count", {31'd0, d[8]}, 32'd1);
        strobe(10'h3C3, ch, act, bs); chk("R7 none enabled", {31'd0, act}, 32'd0);
        rd(8'h1C, d, e); chk("R7 none enabled holds", d, 32'h01AC_0000);
        wr(8'h00, 32'h0003_000E);
        rd(8'h00, d, e); chk("R4 ready cleared by disable", {31'd0, d[8]}, 32'd0);
        strobe(10'h3C3, ch, act, bs); chk("R7 disabled inactive", {31'd0, act}, 32'd0);
        wr(8'h00, 32'h0003_000F);
        for (int i = 0; i < INIT; i++) strobe(10'h000, ch, act, bs);
        strobe(10'h077, ch, act, bs); chk("R4 restart at ch0", ch, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_ctrl_fields();
                t_trim();
                t_errors();
                t_init_and_scan();
                t_battery();
                t_idle();
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule